// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Divider

This block derives the bit timing of a serial bus master from a fast input clock. Two programmable prescale stages, with factors of one to four and one to sixty-four, are placed in series. They pace a fixed 22-step sequencer, and one full pass of that sequencer is one serial bit. The resulting bit rate is the input rate divided by 22 × (A+1) × (B+1), so a bit can never be shorter than 22 input cycles.

The two divider values are read straight from a 16-bit control word. A bit engine downstream uses four one-cycle phase strobes that mark the quarter points of each bit, and it uses an end-of-bit pulse. Because 22 does not divide by four, the quarter points fall at the ends of steps 0, 5, 11 and 16. Software chooses the divider values. The block captures them only at a bit boundary or while it is disabled, so a bit already in progress is never shortened or stretched.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `phase_strobe` and `bit_end` are all low.
- R2: The first divider value A is taken from `ctrl_word[15:14]` and the second, B, from `ctrl_word[13:8]`. Bits 7:0 of the control word have no effect on any output.
- R3: With the block enabled, every sequencer step lasts N = (A+1)×(B+1) input cycles and a bit lasts 22 steps. `bit_end` is a one-cycle pulse seen after the enabled rising edge numbered 22·N·j (j ≥ 1), counting from the first edge sampled with `enable` high.
- R4: `phase_strobe[k]` pulses for one cycle after enabled edge (22·j + s_k + 1)·N, where s_0..s_3 = 0, 5, 11, 16. This is the end of step s_k of each bit.
- R5: At most one bit of `phase_strobe` is high in any cycle, and no strobe is high together with `bit_end`.
- R6: Consecutive `bit_end` pulses are never closer than 22 input cycles, the spacing reached with A = B = 0.
- R7: A change of the divider fields during a bit takes effect only from the next bit. The current bit finishes with the old step length.
- R8: While `enable` is low, all counters are held at zero and every output is low from the next edge on. After `enable` rises, timing restarts at step 0 with the divider values present while the block was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low holds the dividers at zero |
| ctrl_word | input | 16 | Control word carrying the two divider fields |
| phase_strobe | output | 4 | Quarter-point strobes, bit k for quarter k |
| bit_end | output | 1 | One-cycle pulse at the end of each bit |

## Verification
Every output is registered. A strobe or end pulse therefore becomes visible one edge after the input cycle that closes its step, which lands exactly on enabled edge m·N. The bench keeps a count of enabled edges and an arithmetic step position on the rising edge, driven only by the ports. It compares the design's outputs on the following falling edge, when both have settled. Stimulus also changes only on falling edges. For a new configuration, the control word is applied at least one edge before `enable` rises, so the value captured while disabled is the one that governs the first bit.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int CTRL_W      = 16;
    localparam int DIV_A_W     = 2;
    localparam int DIV_A_LSB   = 14;
    localparam int DIV_B_W     = 6;
    localparam int DIV_B_LSB   = 8;
    localparam int STEP_COUNT  = 22;
    localparam int PHASE_COUNT = 4;

    typedef struct packed {
        logic [DIV_A_W-1:0] a;
        logic [DIV_B_W-1:0] b;
    } div_cfg_t;

    function automatic div_cfg_t decode_cfg(input logic [CTRL_W-1:0] word);
        div_cfg_t cfg;
        cfg.a = word[DIV_A_LSB +: DIV_A_W];
        cfg.b = word[DIV_B_LSB +: DIV_B_W];
        return cfg;
    endfunction

    // Step index that closes quarter k of a bit (rounded down).
    function automatic int phase_step(input int k, input int steps);
        return (k * steps) / PHASE_COUNT;
    endfunction

endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = run && adv && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_step_seq.sv
module scl_step_seq
    import scl_div_pkg::*;
#(
    parameter int STEPS  = STEP_COUNT,
    parameter int PHASES = PHASE_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              adv,
    output logic              wrap_now,
    output logic [PHASES-1:0] phase_q,
    output logic              end_q
);
    localparam int CW = $clog2(STEPS);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0]     step_q;
    logic [PHASES-1:0] hit;

    assign wrap_now = run && adv && (step_q == LAST);

    generate
        for (genvar k = 0; k < PHASES; k++) begin : g_phase
            localparam logic [CW-1:0] POS = CW'(phase_step(k, STEPS));
            assign hit[k] = (step_q == POS);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step_q  <= '0;
            phase_q <= '0;
            end_q   <= 1'b0;
        end else begin
            phase_q <= adv ? hit : '0;
            end_q   <= wrap_now;
            if (adv) begin
                step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic [CTRL_W-1:0]      ctrl_word,
    output logic [PHASE_COUNT-1:0] phase_strobe,
    output logic                   bit_end
);
    div_cfg_t           cfg_q;
    logic [DIV_A_W-1:0] cur_a;
    logic [DIV_B_W-1:0] cur_b;
    logic               tick_a;
    logic               tick_b;
    logic               period_wrap;

    assign cur_a = cfg_q.a;
    assign cur_b = cfg_q.b;

    // Divider values are captured only while idle or as a bit closes.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!enable || period_wrap) begin
            cfg_q <= decode_cfg(ctrl_word);
        end
    end

    scl_div_stage #(.W(DIV_A_W)) u_stage_a (
        .clk   (clk),
        .rst   (rst),
        .run   (enable),
        .adv   (1'b1),
        .limit (cur_a),
        .wrap  (tick_a)
    );

    scl_div_stage #(.W(DIV_B_W)) u_stage_b (
        .clk   (clk),
        .rst   (rst),
        .run   (enable),
        .adv   (tick_a),
        .limit (cur_b),
        .wrap  (tick_b)
    );

    scl_step_seq #(.STEPS(STEP_COUNT), .PHASES(PHASE_COUNT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (enable),
        .adv      (tick_b),
        .wrap_now (period_wrap),
        .phase_q  (phase_strobe),
        .end_q    (bit_end)
    );
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk
    import scl_div_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   enable,
    input logic [PHASE_COUNT-1:0] phase_strobe,
    input logic                   bit_end,
    input logic [DIV_A_W-1:0]     cur_a,
    input logic [DIV_B_W-1:0]     cur_b,
    input logic                   period_wrap
);
    localparam int GW = $clog2(STEP_COUNT + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (bit_end) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(STEP_COUNT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_strobe));

    assert_strobe_not_with_end_R5: assert property (@(posedge clk) disable iff (rst)
        bit_end |-> (phase_strobe == '0));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ((phase_strobe == '0) && !bit_end));

    assert_min_period_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_end && seen_q) |-> (gap_q >= GW'(STEP_COUNT - 1)));

    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable) && !$past(period_wrap)) |-> $stable({cur_a, cur_b}));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .phase_strobe (phase_strobe),
    .bit_end      (bit_end),
    .cur_a        (cur_a),
    .cur_b        (cur_b),
    .period_wrap  (period_wrap)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS = 22;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [15:0] ctrl_word;
    logic [3:0]  phase_strobe;
    logic        bit_end;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Arithmetic reference state, updated from the ports only.
    int         n_cur = 1;
    int         cyc   = 0;
    int         en_e  = 0;
    logic [3:0] exp_ph  = '0;
    logic       exp_end = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_phase_gen u_dut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .ctrl_word    (ctrl_word),
        .phase_strobe (phase_strobe),
        .bit_end      (bit_end)
    );

    function automatic int step_len(input logic [15:0] w);
        return (int'(w[15:14]) + 1) * (int'(w[13:8]) + 1);
    endfunction

    function automatic int quarter_pos(input int k);
        return (k * STEPS) / 4;
    endfunction

    always @(posedge clk) begin
        int c;
        int s;
        logic [3:0] ph;
        if (rst || !enable) begin
            exp_ph  <= '0;
            exp_end <= 1'b0;
            cyc     <= 0;
            en_e    <= 0;
            n_cur   <= step_len(ctrl_word);
        end else begin
            c  = cyc + 1;
            ph = '0;
            en_e <= en_e + 1;
            if (c % n_cur == 0) begin
                s = (c / n_cur - 1) % STEPS;
                for (int k = 0; k < 4; k++) ph[k] = (s == quarter_pos(k));
                exp_end <= (s == STEPS - 1);
            end else begin
                exp_end <= 1'b0;
            end
            exp_ph <= ph;
            if (c == STEPS * n_cur) begin
                cyc   <= 0;
                n_cur <= step_len(ctrl_word);
            end else begin
                cyc <= c;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    int end_seen;
    int ph_seen[4];
    int end_at[2];

    // Advance n falling edges, comparing every cycle with the reference.
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(phase_strobe == exp_ph, enable ? "R4" : "R8", phase_strobe, exp_ph);
            check(bit_end == exp_end, enable ? "R3" : "R8", bit_end, exp_end);
            check($onehot0(phase_strobe) && !(bit_end && phase_strobe != 0), "R5",
                  {bit_end, phase_strobe}, 0);
            if (bit_end) begin
                if (end_seen < 2) end_at[end_seen] = en_e;
                end_seen = end_seen + 1;
            end
            for (int k = 0; k < 4; k++) if (phase_strobe[k]) ph_seen[k] = ph_seen[k] + 1;
        end
    endtask

    task automatic clear_counts();
        end_seen = 0;
        for (int k = 0; k < 4; k++) ph_seen[k] = 0;
        end_at[0] = 0;
        end_at[1] = 0;
    endtask

    initial begin
        int bvals[7];
        int n;
        bvals = '{0, 1, 2, 3, 7, 31, 63};
        rst = 1'b1;
        enable = 1'b0;
        ctrl_word = 16'h0000;
        repeat (3) @(negedge clk);
        check(phase_strobe == 4'b0 && !bit_end, "R1", {bit_end, phase_strobe}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(phase_strobe == 4'b0 && !bit_end, "R1", {bit_end, phase_strobe}, 0);
        run_cycles(2);

        // Sweep of divider values; low control bits carry junk (R2).
        for (int a = 0; a < 4; a++) begin
            for (int bi = 0; bi < 7; bi++) begin
                n = (a + 1) * (bvals[bi] + 1);
                enable = 1'b0;
                ctrl_word = {2'(a), 6'(bvals[bi]), 8'((a * 37 + bi * 91) ^ 8'h5A)};
                run_cycles(2);
                clear_counts();
                enable = 1'b1;
                run_cycles(24 * n + 3);
                check(end_seen == 1, "R3", end_seen, 1);
                check(end_at[0] == STEPS * n, "R2", end_at[0], STEPS * n);
                check(ph_seen[0] == 2, "R4", ph_seen[0], 2);
                check(ph_seen[1] == 1 && ph_seen[2] == 1 && ph_seen[3] == 1, "R4",
                      ph_seen[1] + ph_seen[2] + ph_seen[3], 3);
            end
        end

        // Fastest setting: bit period of exactly 22 cycles (R6).
        enable = 1'b0;
        ctrl_word = 16'h00FF;
        run_cycles(2);
        clear_counts();
        enable = 1'b1;
        run_cycles(50);
        check(end_at[1] - end_at[0] == STEPS, "R6", end_at[1] - end_at[0], STEPS);

        // Divider change in the middle of a bit (R7): N=6 then N=2.
        enable = 1'b0;
        ctrl_word = {2'd1, 6'd2, 8'h00};
        run_cycles(2);
        clear_counts();
        enable = 1'b1;
        run_cycles(40);
        ctrl_word = {2'd0, 6'd1, 8'hC3};
        run_cycles(150);
        check(end_at[0] == 132, "R7", end_at[0], 132);
        check(end_at[1] == 176, "R7", end_at[1], 176);

        // Disable in mid-bit, then restart from step 0 (R8).
        run_cycles(7);
        enable = 1'b0;
        run_cycles(1);
        check(phase_strobe == 4'b0 && !bit_end, "R8", {bit_end, phase_strobe}, 0);
        clear_counts();
        enable = 1'b1;
        run_cycles(2);
        check(ph_seen[0] == 1, "R8", ph_seen[0], 1);
        run_cycles(50);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule